// File: doc/BRIEF.md
# Receive Idle Time-out Counter

This block watches the receive side of a serial port and reports when the incoming character stream has gone quiet. Each time a finished character is moved from the receive shift register into the receive FIFO, the block restarts a 16-bit down-counter from a value that software splits across two 8-bit preload registers. If the count runs out before the next character arrives, a ready flag is set. An interrupt request can follow if it is not masked.

Software programs the preload to a little more than one character time. A message that ends with the FIFO only partly filled is then still flagged, and so is a line that has stayed idle at mark after the FIFO was drained. Commands written to an 8-bit command port turn this mode on and off. When the mode is off, the same counter works as an ordinary one-shot counter, started and stopped by command. While the mode is on, those start and stop commands are ignored.

Top module: `rxto_timer`

## Requirements
- R1: After a synchronous reset, `ready` and `irq` are 0, time-out mode is off and the counter is stopped. A `char_push` before any command therefore never sets `ready`.
- R2: In time-out mode, a `char_push` stops the counter. The first cycle after it with `tick` high loads {`preload_hi`,`preload_lo`} (upper byte in bits 15:8). Each later `tick` decrements the count. A `tick` that finds the count at zero sets `ready`. With preload N and no further pushes, `ready` rises on the (N+2)-th tick after the push. A push before then restarts the sequence.
- R3: The count advances only on cycles where `tick` is 1. Cycles with `tick` at 0 leave the count where it is.
- R4: `irq` is registered on the same edge as `ready` and equals the new `ready` AND `irq_mask`. It is therefore never 1 while `ready` is 0.
- R5: After expiry the counter stays stopped at zero and `ready` holds. Further ticks change nothing until a push, a clear or a command.
- R6: `sts_clr` clears `ready`. If an expiry happens in the same cycle, the expiry wins and `ready` becomes 1.
- R7: A `char_push` in the same cycle as a `tick` takes priority: that tick neither decrements nor expires, and the reload tick is the next one.
- R8: A preload of zero sets `ready` on the second tick after the push.
- R9: A command write whose upper nibble (`cmd_data[7:4]`) is 0xA turns time-out mode on and clears `ready`. It leaves the counter stopped until the next `char_push`.
- R10: A command write with upper nibble 0xC turns time-out mode off, clears `ready` and stops the counter. `char_push` is then ignored.
- R11: While time-out mode is on, the start-counter command (upper nibble 0x8) and the stop-counter command (upper nibble 0x9) have no effect.
- R12: While time-out mode is off, a start command behaves as a push does in R2: it loads on the next tick, counts down, and sets `ready` once at expiry. A stop command halts the count.
- R13: A recognised command in the same cycle as `char_push` wins over the push. Upper nibbles other than 0x8, 0x9, 0xA and 0xC have no effect, and neither does the lower nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| char_push | input | 1 | One-cycle pulse per character written into the receive FIFO |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte; the opcode is in the upper nibble |
| preload_hi | input | 8 | Upper byte of the reload value |
| preload_lo | input | 8 | Lower byte of the reload value |
| sts_clr | input | 1 | Clears the ready flag |
| irq_mask | input | 1 | Interrupt enable for the expiry |
| ready | output | 1 | Counter-ready status flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 8-bit preload bytes and 8-bit command byte, so the counter is the full 16 bits wide. Most stimulus uses preloads of 0 to 5, which makes expiry frequent enough that random pushes, ticks, clears and commands collide with it often. One directed run loads 0x0100, which puts the upper byte in play and checks that the bytes are joined in the right order across 258 ticks.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

  localparam logic [3:0] OP_CTR_START = 4'h8;
  localparam logic [3:0] OP_CTR_STOP  = 4'h9;
  localparam logic [3:0] OP_TMO_ON    = 4'hA;
  localparam logic [3:0] OP_TMO_OFF   = 4'hC;

  typedef struct packed {
    logic tmo_on;
    logic tmo_off;
    logic ctr_start;
    logic ctr_stop;
  } cmd_t;

endpackage

// File: rtl/rxto_cmd_dec.sv
module rxto_cmd_dec
  import rxto_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  output cmd_t             cmd
);
  localparam int OP_W = 4;

  logic [OP_W-1:0] opcode;
  logic            unused_low;

  assign opcode     = cmd_data[CMD_W-1 -: OP_W];
  assign unused_low = ^cmd_data[CMD_W-OP_W-1:0];

  always_comb begin
    cmd           = '0;
    cmd.tmo_on    = cmd_we && (opcode == OP_TMO_ON);
    cmd.tmo_off   = cmd_we && (opcode == OP_TMO_OFF);
    cmd.ctr_start = cmd_we && (opcode == OP_CTR_START);
    cmd.ctr_stop  = cmd_we && (opcode == OP_CTR_STOP);
  end

endmodule

// File: rtl/rxto_mode_ctl.sv
module rxto_mode_ctl
  import rxto_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cmd_t cmd,
  input  logic char_push,
  output logic tmo_mode,
  output logic arm,
  output logic halt,
  output logic clr_cmd
);
  logic mode_q;

  always_ff @(posedge clk) begin
    if (rst)              mode_q <= 1'b0;
    else if (cmd.tmo_on)  mode_q <= 1'b1;
    else if (cmd.tmo_off) mode_q <= 1'b0;
  end

  assign tmo_mode = mode_q;
  assign clr_cmd  = cmd.tmo_on | cmd.tmo_off;

  always_comb begin
    halt = clr_cmd | (!mode_q & cmd.ctr_stop);
    arm  = !halt & (mode_q ? char_push : cmd.ctr_start);
  end

  // R9
  mode_on_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.tmo_on |=> mode_q);

  // R10
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.tmo_off && !cmd.tmo_on) |=> !mode_q);

endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             arm,
  input  logic             halt,
  input  logic [CNT_W-1:0] preload,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             pend_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = tick && run_q && at_zero && !arm && !halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (halt) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (arm) begin
      run_q  <= 1'b0;
      pend_q <= 1'b1;
    end else if (tick) begin
      if (pend_q) begin
        cnt_q  <= preload;
        run_q  <= 1'b1;
        pend_q <= 1'b0;
      end else if (run_q) begin
        if (at_zero) run_q <= 1'b0;
        else         cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !arm && !halt) |=> ($stable(cnt_q) && $stable(run_q)));

  // R7
  arm_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && !halt) |=> (pend_q && !run_q));

  // R5
  stop_after_expire_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (!run_q && !pend_q && cnt_q == '0));

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && tick && !arm && !halt) |=> (run_q && cnt_q == $past(preload)));

  // R2
  run_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(run_q && pend_q));

endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr_cmd,
  input  logic sts_clr,
  input  logic irq_mask,
  output logic ready,
  output logic irq
);
  logic ready_q, irq_q, ready_n;

  always_comb begin
    if (clr_cmd)      ready_n = 1'b0;
    else if (expire)  ready_n = 1'b1;
    else if (sts_clr) ready_n = 1'b0;
    else              ready_n = ready_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ready_q <= ready_n;
      irq_q   <= ready_n & irq_mask;
    end
  end

  assign ready = ready_q;
  assign irq   = irq_q;

  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ready_q);

  // R4
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_mask |=> !irq_q);

  // R5
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !clr_cmd && !sts_clr) |=> ready_q);

  // R9
  cmd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> !ready_q);

  // R6
  expire_set_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !clr_cmd) |=> ready_q);

endmodule

// File: rtl/rxto_timer.sv
module rxto_timer
  import rxto_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             char_push,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic [PRE_W-1:0] preload_hi,
  input  logic [PRE_W-1:0] preload_lo,
  input  logic             sts_clr,
  input  logic             irq_mask,
  output logic             ready,
  output logic             irq
);
  localparam int CNT_W = 2 * PRE_W;

  cmd_t             cmd;
  logic             tmo_mode, arm, halt, clr_cmd, expire;
  logic [CNT_W-1:0] preload;

  assign preload = {preload_hi, preload_lo};

  rxto_cmd_dec #(.CMD_W(CMD_W)) u_dec (
    .cmd_we   (cmd_we),
    .cmd_data (cmd_data),
    .cmd      (cmd)
  );

  rxto_mode_ctl u_mode (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .char_push (char_push),
    .tmo_mode  (tmo_mode),
    .arm       (arm),
    .halt      (halt),
    .clr_cmd   (clr_cmd)
  );

  rxto_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .arm     (arm),
    .halt    (halt),
    .preload (preload),
    .expire  (expire)
  );

  rxto_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .expire   (expire),
    .clr_cmd  (clr_cmd),
    .sts_clr  (sts_clr),
    .irq_mask (irq_mask),
    .ready    (ready),
    .irq      (irq)
  );

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (tmo_mode && cmd.ctr_start && !char_push && !ready && !expire) |=> !ready);

endmodule

// File: tb/rxto_timer_bench.sv
module rxto_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 0, char_push = 0, cmd_we = 0, sts_clr = 0, irq_mask = 0;
  logic [7:0] cmd_data = 0, preload_hi = 0, preload_lo = 0;
  logic       ready, irq;

  int n_chk = 0, n_fail = 0;
  bit use_model = 0;

  bit m_mode, m_run, m_pend, m_rdy, m_irq;
  int m_cnt;

  always #4 clk = ~clk;

  rxto_timer u_rxto_timer (
    .clk(clk), .rst(rst), .tick(tick), .char_push(char_push),
    .cmd_we(cmd_we), .cmd_data(cmd_data), .preload_hi(preload_hi),
    .preload_lo(preload_lo), .sts_clr(sts_clr), .irq_mask(irq_mask),
    .ready(ready), .irq(irq)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_mode = 0; m_run = 0; m_pend = 0; m_rdy = 0; m_irq = 0; m_cnt = 0;
  endfunction

  // Reference from R2..R13, evaluated with the inputs of one cycle.
  function automatic void model_step(bit t, bit p, bit we, logic [7:0] c, bit clr, bit msk);
    bit on, off, st, sp, ex;
    on  = we && c[7:4] == 4'hA;
    off = we && c[7:4] == 4'hC;
    st  = we && c[7:4] == 4'h8 && !m_mode;
    sp  = we && c[7:4] == 4'h9 && !m_mode;
    ex  = 0;
    if (on || off || sp) begin
      m_run = 0; m_pend = 0;
    end else if (m_mode ? p : st) begin
      m_run = 0; m_pend = 1;
    end else if (t) begin
      if (m_pend) begin
        m_cnt = {preload_hi, preload_lo}; m_run = 1; m_pend = 0;
      end else if (m_run) begin
        if (m_cnt == 0) begin ex = 1; m_run = 0; end
        else m_cnt = m_cnt - 1;
      end
    end
    if (on || off) m_rdy = 0;
    else if (ex)   m_rdy = 1;
    else if (clr)  m_rdy = 0;
    m_irq = m_rdy & msk;
    if (on) m_mode = 1;
    else if (off) m_mode = 0;
  endfunction

  task automatic drive(bit t, bit p, bit we, logic [7:0] c, bit clr);
    tick = t; char_push = p; cmd_we = we; cmd_data = c; sts_clr = clr;
    if (use_model) model_step(t, p, we, c, clr, irq_mask);
    @(negedge clk);
    tick = 0; char_push = 0; cmd_we = 0; cmd_data = 0; sts_clr = 0;
    if (use_model) begin
      chk("R2 model ready", ready, m_rdy);
      chk("R4 model irq", irq, m_irq);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 8'h00, 0);
  endtask

  task automatic push();
    drive(0, 1, 0, 8'h00, 0);
  endtask

  task automatic clear();
    drive(0, 0, 0, 8'h00, 1);
  endtask

  task automatic command(logic [7:0] c);
    drive(0, 0, 1, c, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset ready", ready, 0);
    chk("R1 reset irq", irq, 0);
    preload_lo = 8'd3; irq_mask = 1;
    push(); ticks(10);
    chk("R1 mode off after reset", ready, 0);

    command(8'hA0);
    push(); ticks(4);
    chk("R2 not yet expired", ready, 0);
    ticks(1);
    chk("R2 expiry at N+2", ready, 1);
    chk("R4 irq with mask", irq, 1);
    ticks(5);
    chk("R5 ready held", ready, 1);
    irq_mask = 0; drive(0, 0, 0, 8'h00, 0);
    chk("R4 irq masked", irq, 0);
    chk("R4 ready unaffected by mask", ready, 1);
    irq_mask = 1; drive(0, 0, 0, 8'h00, 0);
    chk("R4 irq unmasked", irq, 1);
    clear();
    chk("R6 sts_clr clears", ready, 0);
    ticks(10);
    chk("R5 counter stopped at zero", ready, 0);

    push(); repeat (20) drive(0, 0, 0, 8'h00, 0);
    chk("R3 no count without tick", ready, 0);
    ticks(4);
    chk("R3 gated count early", ready, 0);
    ticks(1);
    chk("R3 gated count expiry", ready, 1);
    clear();

    push(); ticks(3); push(); ticks(4);
    chk("R2 restart by push", ready, 0);
    ticks(1);
    chk("R2 restart expiry", ready, 1);
    clear();

    push(); ticks(4); drive(1, 1, 0, 8'h00, 0);
    chk("R7 push beats tick", ready, 0);
    ticks(4);
    chk("R7 reload on next tick", ready, 0);
    ticks(1);
    chk("R7 expiry after coincident push", ready, 1);
    clear();

    push(); ticks(4); drive(1, 0, 0, 8'h00, 1);
    chk("R6 expiry beats clear", ready, 1);
    clear();

    preload_lo = 0;
    push(); ticks(1);
    chk("R8 zero preload first tick", ready, 0);
    ticks(1);
    chk("R8 zero preload second tick", ready, 1);

    command(8'hA3);
    chk("R9 enable clears ready", ready, 0);
    chk("R9 enable clears irq", irq, 0);
    ticks(10);
    chk("R9 stopped until push", ready, 0);
    push(); ticks(2);
    chk("R9 push restarts", ready, 1);
    clear();

    preload_lo = 3;
    command(8'h80); ticks(10);
    chk("R11 start ignored", ready, 0);
    push(); ticks(3); command(8'h90); ticks(2);
    chk("R11 stop ignored", ready, 1);
    clear();

    push(); ticks(4); drive(1, 0, 1, 8'h5F, 0);
    chk("R13 unknown opcode ignored", ready, 1);
    drive(0, 1, 1, 8'hC7, 0);
    chk("R10 disable clears ready", ready, 0);
    ticks(10);
    chk("R10 counter stopped", ready, 0);
    push(); ticks(10);
    chk("R10 push ignored", ready, 0);

    preload_lo = 2;
    command(8'h80); ticks(3);
    chk("R12 start early", ready, 0);
    ticks(1);
    chk("R12 start expiry", ready, 1);
    clear();
    command(8'h80); ticks(2); command(8'h90); ticks(5);
    chk("R12 stop halts", ready, 0);

    preload_lo = 0;
    drive(0, 1, 1, 8'hA0, 0); ticks(5);
    chk("R13 command beats push", ready, 0);

    preload_hi = 1; preload_lo = 0;
    push(); ticks(257);
    chk("R2 upper byte early", ready, 0);
    ticks(1);
    chk("R2 upper byte expiry", ready, 1);

    rst = 1; @(negedge clk); rst = 0;
    model_reset();
    preload_hi = 0;
    use_model = 1;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] c;
      int sel;
      if ($urandom_range(0, 49) == 0) preload_lo = 8'($urandom_range(0, 5));
      if ($urandom_range(0, 39) == 0) irq_mask = ~irq_mask;
      sel = $urandom_range(0, 4);
      c = {(sel == 0) ? 4'h8 : (sel == 1) ? 4'h9 : (sel == 2) ? 4'hA :
           (sel == 3) ? 4'hC : 4'h5, 4'($urandom_range(0, 15))};
      drive($urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0,
            $urandom_range(0, 29) == 0, c, $urandom_range(0, 29) == 0);
    end
    use_model = 0;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule